// File: doc/BRIEF.md
# Two-Way Cache Maintenance Engine

This block owns the per-line state of a two-way set-associative cache (a valid flag, a modified flag and a tag for every entry) and carries out maintenance commands on it. A command is loaded through a few command fields and started with a one-cycle `go` pulse. A whole-cache command visits every entry of both ways. A line command takes a line address, searches both ways of the addressed set and acts on the way whose tag matches. When a command meets a line that is both valid and modified and the command includes a push, the engine raises a write-back request that carries the line address. It holds that request until the memory side acknowledges it, and only then updates the entry and continues.

The line fill path of the normal cache logic writes entries through a fill port. Software or the cache controller reads the state back through a combinational peek port. A separate enable request runs an invalidate of the whole cache before the cache is reported enabled, and a push of the whole cache before it is reported disabled. `busy` is high for the whole time a command or an enable change is running.

Top module: `cache_maint_engine`

## Requirements
- R1: After reset `busy`, `cache_en` and `wb_req` are 0 and every entry of both ways reads as not valid and not modified.
- R2: A line invalidate (`cmd_line_op` = 01) clears both the valid and the modified flag of the way that hits, whatever their state, and never raises `wb_req`.
- R3: A line push (`cmd_line_op` = 10) on a valid, modified line raises `wb_req` with `wb_line` = {tag, set} and, after `wb_ack`, clears only the modified flag. On a line that is not modified, a push raises no request and changes nothing. The valid flag is never changed by a push.
- R4: A line clear (`cmd_line_op` = 11) writes back a valid, modified line and then clears both flags. On any other hitting line it clears the valid flag with no write-back.
- R5: A line command whose {tag, set} matches no valid way keeps `busy` high for exactly 2 cycles, raises no request and changes no entry. A line command that hits and needs no write-back also takes 2 cycles.
- R6: A whole-cache command (`cmd_push_all` and/or `cmd_inv_all` set) visits set 0 to the last set in ascending order, way 0 before way 1. Push-all with invalidate-all means clear-all. With no write-back, the walk takes exactly 2 × SETS cycles of `busy`. When either all-bit is set, `cmd_line_op` is ignored.
- R7: Write-backs are issued one at a time. `wb_req` stays high with a stable `wb_line` until `wb_ack`, and the command makes no progress while it waits.
- R8: `busy` rises on the clock edge that accepts `go` and falls when the command completes. A `go` that arrives while `busy` is high is ignored. The command fields are sampled only on an accepted `go`.
- R9: Raising `en_req` runs an invalidate-all and sets `cache_en` as it completes. Lowering it runs a push-all and clears `cache_en` as it completes. `busy` is high during either sequence. An accepted `go` takes precedence on the same cycle.
- R10: A `go` with both all-bits low and `cmd_line_op` = 00 is a no-operation: `busy` does not rise and no entry changes.
- R11: When idle, a fill writes the tag, sets the valid flag and sets the modified flag from `fill_dirty`. Fills arriving while `busy` is high are dropped. The peek port shows the state at `peek_set` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| go | input | 1 | Start pulse for a command |
| cmd_push_all | input | 1 | Whole-cache push request |
| cmd_inv_all | input | 1 | Whole-cache invalidate request |
| cmd_line_op | input | 2 | Line command: 01 invalidate, 10 push, 11 clear, 00 none |
| cmd_line | input | LINE_W | Line address {tag, set} for a line command |
| en_req | input | 1 | Requested cache enable state |
| busy | output | 1 | Command or enable sequence in progress |
| cache_en | output | 1 | Current cache enable state |
| wb_req | output | 1 | Write-back request for a modified line |
| wb_line | output | LINE_W | Line address {tag, set} of the write-back |
| wb_ack | input | 1 | Write-back accepted |
| fill_en | input | 1 | Fill strobe |
| fill_way | input | 1 | Way to fill |
| fill_set | input | SET_W | Set to fill |
| fill_tag | input | TAG_W | Tag written by the fill |
| fill_dirty | input | 1 | Modified flag written by the fill |
| peek_set | input | SET_W | Set shown on the peek outputs |
| peek_valid | output | 2 | Valid flags of way 1 and way 0 at `peek_set` |
| peek_dirty | output | 2 | Modified flags of way 1 and way 0 at `peek_set` |
| peek_tag | output | 2*TAG_W | Tags {way 1, way 0} at `peek_set` |

## Verification
The bench goes after the state-dependent corners of push, invalidate and clear. A clean line under push must keep its valid flag and raise no request. A clean line under clear must lose only its valid flag. A design that mixes these up shows the wrong flags on the peek port or sends write-backs nobody expected. It times a missing line command and a full invalidate walk, because an engine that skips or repeats entries, or stalls on a miss, gives the wrong busy length. It issues a `go` in the middle of a walk and changes the command fields while busy: an engine that re-samples them pushes lines that should only have been invalidated. Write-back order and addresses are compared entry by entry under random acknowledge delays, which catches a walk that advances without waiting for the acknowledge.

// File: rtl/cme_pkg.sv
package cme_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WALK,
    ST_LOOK,
    ST_ACT,
    ST_WB
  } eng_state_e;

  // Line command encoding: bit 1 = push, bit 0 = invalidate.
  localparam logic [1:0] LOP_NONE  = 2'b00;
  localparam logic [1:0] LOP_INV   = 2'b01;
  localparam logic [1:0] LOP_PUSH  = 2'b10;
  localparam logic [1:0] LOP_CLEAR = 2'b11;

  // Flags after the operation is applied: {valid, modified}.
  function automatic logic [1:0] entry_after(logic v, logic d, logic push, logic inv);
    if (inv)       return 2'b00;
    else if (push) return {v, 1'b0};
    else           return {v, d};
  endfunction

  function automatic logic entry_needs_wb(logic v, logic d, logic push);
    return push & v & d;
  endfunction

endpackage

// File: rtl/cme_tag_store.sv
module cme_tag_store #(
  parameter int SETS  = 16,
  parameter int SET_W = 4,
  parameter int TAG_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  fill_en,
  input  logic                  fill_way,
  input  logic [SET_W-1:0]      fill_set,
  input  logic [TAG_W-1:0]      fill_tag,
  input  logic                  fill_dirty,
  input  logic [SET_W-1:0]      eng_set,
  input  logic                  upd_en,
  input  logic                  upd_way,
  input  logic                  upd_v,
  input  logic                  upd_d,
  output logic [1:0]            eng_v,
  output logic [1:0]            eng_d,
  output logic [1:0][TAG_W-1:0] eng_tag,
  input  logic [SET_W-1:0]      peek_set,
  output logic [1:0]            pk_v,
  output logic [1:0]            pk_d,
  output logic [1:0][TAG_W-1:0] pk_tag
);

  for (genvar w = 0; w < 2; w++) begin : g_way
    localparam logic WAY_ID = 1'(w);
    logic [SETS-1:0]  vld;
    logic [SETS-1:0]  mod;
    logic [TAG_W-1:0] tg [SETS];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld <= '0;
        mod <= '0;
        for (int s = 0; s < SETS; s++) tg[s] <= '0;
      end else begin
        if (fill_en && fill_way == WAY_ID) begin
          vld[fill_set] <= 1'b1;
          mod[fill_set] <= fill_dirty;
          tg[fill_set]  <= fill_tag;
        end
        if (upd_en && upd_way == WAY_ID) begin
          vld[eng_set] <= upd_v;
          mod[eng_set] <= upd_d;
        end
      end
    end

    assign eng_v[w]   = vld[eng_set];
    assign eng_d[w]   = mod[eng_set];
    assign eng_tag[w] = tg[eng_set];
    assign pk_v[w]    = vld[peek_set];
    assign pk_d[w]    = mod[peek_set];
    assign pk_tag[w]  = tg[peek_set];
  end

endmodule

// File: rtl/cme_way_match.sv
module cme_way_match #(
  parameter int TAG_W = 8
) (
  input  logic [1:0]            v,
  input  logic [1:0][TAG_W-1:0] tags,
  input  logic [TAG_W-1:0]      look_tag,
  output logic                  hit,
  output logic                  hit_way
);

  logic [1:0] eq;

  for (genvar w = 0; w < 2; w++) begin : g_cmp
    assign eq[w] = v[w] && (tags[w] == look_tag);
  end

  assign hit     = |eq;
  assign hit_way = ~eq[0];   // way 0 wins when both match

endmodule

// File: rtl/cme_engine.sv
module cme_engine
  import cme_pkg::*;
#(
  parameter int SET_W = 4,
  parameter int TAG_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   go,
  input  logic                   cmd_push_all,
  input  logic                   cmd_inv_all,
  input  logic [1:0]             cmd_line_op,
  input  logic [TAG_W+SET_W-1:0] cmd_line,
  input  logic                   en_req,
  input  logic                   wb_ack,
  input  logic [1:0]             tv,
  input  logic [1:0]             td,
  input  logic [1:0][TAG_W-1:0]  ttag,
  input  logic                   hit,
  input  logic                   hit_way,
  output logic                   busy,
  output logic                   cache_en,
  output logic                   wb_req,
  output logic [TAG_W+SET_W-1:0] wb_line,
  output logic [SET_W-1:0]       cur_set,
  output logic [TAG_W-1:0]       look_tag,
  output logic                   upd_en,
  output logic                   upd_way,
  output logic                   upd_v,
  output logic                   upd_d,
  output logic                   walk_last,
  output logic                   line_miss,
  output logic                   wb_done
);

  eng_state_e       state;
  logic             whole_q, push_q, inv_q, seq_q, hit_q, en_q;
  logic [SET_W-1:0] set_q;
  logic             way_q;
  logic [TAG_W-1:0] tag_q;

  logic             ev, ed, need_wb;
  logic [1:0]       after;
  logic [SET_W:0]   walk_nx;
  logic             take_whole, take_line, take_en;

  assign ev        = tv[way_q];
  assign ed        = td[way_q];
  assign need_wb   = entry_needs_wb(ev, ed, push_q);
  assign after     = entry_after(ev, ed, push_q, inv_q);
  assign walk_nx   = {set_q, way_q} + {{SET_W{1'b0}}, 1'b1};
  assign walk_last = (set_q == {SET_W{1'b1}}) && way_q;
  assign wb_done   = (state == ST_WB) && wb_ack;
  assign line_miss = (state == ST_ACT) && !hit_q;

  assign take_whole = go && (cmd_push_all || cmd_inv_all);
  assign take_line  = go && !take_whole && (cmd_line_op != LOP_NONE);
  assign take_en    = !take_whole && !take_line && (en_req != en_q);

  assign upd_en  = ((state == ST_WALK) && !need_wb) ||
                   ((state == ST_ACT) && hit_q && !need_wb) || wb_done;
  assign upd_way = way_q;
  assign upd_v   = after[1];
  assign upd_d   = after[0];

  assign busy     = (state != ST_IDLE);
  assign cache_en = en_q;
  assign wb_req   = (state == ST_WB);
  assign wb_line  = {ttag[way_q], set_q};
  assign cur_set  = set_q;
  assign look_tag = tag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      whole_q <= 1'b0;
      push_q  <= 1'b0;
      inv_q   <= 1'b0;
      seq_q   <= 1'b0;
      hit_q   <= 1'b0;
      en_q    <= 1'b0;
      set_q   <= '0;
      way_q   <= 1'b0;
      tag_q   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (take_whole) begin
            whole_q <= 1'b1;
            seq_q   <= 1'b0;
            push_q  <= cmd_push_all;
            inv_q   <= cmd_inv_all;
            set_q   <= '0;
            way_q   <= 1'b0;
            state   <= ST_WALK;
          end else if (take_line) begin
            whole_q <= 1'b0;
            seq_q   <= 1'b0;
            push_q  <= cmd_line_op[1];
            inv_q   <= cmd_line_op[0];
            set_q   <= cmd_line[SET_W-1:0];
            tag_q   <= cmd_line[TAG_W+SET_W-1:SET_W];
            state   <= ST_LOOK;
          end else if (take_en) begin
            whole_q <= 1'b1;
            seq_q   <= 1'b1;
            push_q  <= !en_req;
            inv_q   <= en_req;
            set_q   <= '0;
            way_q   <= 1'b0;
            state   <= ST_WALK;
          end
        end
        ST_WALK: begin
          if (need_wb) state <= ST_WB;
          else if (walk_last) begin
            state <= ST_IDLE;
            if (seq_q) en_q <= inv_q;
          end else {set_q, way_q} <= walk_nx;
        end
        ST_LOOK: begin
          hit_q <= hit;
          way_q <= hit_way;
          state <= ST_ACT;
        end
        ST_ACT: begin
          if (hit_q && need_wb) state <= ST_WB;
          else                  state <= ST_IDLE;
        end
        ST_WB: begin
          if (wb_ack) begin
            if (!whole_q) state <= ST_IDLE;
            else if (walk_last) begin
              state <= ST_IDLE;
              if (seq_q) en_q <= inv_q;
            end else begin
              {set_q, way_q} <= walk_nx;
              state          <= ST_WALK;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/cache_maint_engine.sv
module cache_maint_engine #(
  parameter int SETS   = 16,
  parameter int TAG_W  = 8,
  localparam int SET_W  = $clog2(SETS),
  localparam int LINE_W = TAG_W + SET_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                go,
  input  logic                cmd_push_all,
  input  logic                cmd_inv_all,
  input  logic [1:0]          cmd_line_op,
  input  logic [LINE_W-1:0]   cmd_line,
  input  logic                en_req,
  output logic                busy,
  output logic                cache_en,
  output logic                wb_req,
  output logic [LINE_W-1:0]   wb_line,
  input  logic                wb_ack,
  input  logic                fill_en,
  input  logic                fill_way,
  input  logic [SET_W-1:0]    fill_set,
  input  logic [TAG_W-1:0]    fill_tag,
  input  logic                fill_dirty,
  input  logic [SET_W-1:0]    peek_set,
  output logic [1:0]          peek_valid,
  output logic [1:0]          peek_dirty,
  output logic [2*TAG_W-1:0]  peek_tag
);

  logic [1:0]            tv, td;
  logic [1:0][TAG_W-1:0] ttag, pk_tag;
  logic [SET_W-1:0]      cur_set;
  logic [TAG_W-1:0]      look_tag;
  logic                  hit, hit_way;
  logic                  upd_en, upd_way, upd_v, upd_d;
  logic                  walk_last, line_miss, wb_done;
  logic                  fill_ok;

  assign fill_ok  = fill_en && !busy;
  assign peek_tag = pk_tag;

  cme_tag_store #(.SETS(SETS), .SET_W(SET_W), .TAG_W(TAG_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .fill_en(fill_ok), .fill_way(fill_way), .fill_set(fill_set),
    .fill_tag(fill_tag), .fill_dirty(fill_dirty),
    .eng_set(cur_set), .upd_en(upd_en), .upd_way(upd_way),
    .upd_v(upd_v), .upd_d(upd_d),
    .eng_v(tv), .eng_d(td), .eng_tag(ttag),
    .peek_set(peek_set), .pk_v(peek_valid), .pk_d(peek_dirty), .pk_tag(pk_tag)
  );

  cme_way_match #(.TAG_W(TAG_W)) u_match (
    .v(tv), .tags(ttag), .look_tag(look_tag), .hit(hit), .hit_way(hit_way)
  );

  cme_engine #(.SET_W(SET_W), .TAG_W(TAG_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .go(go),
    .cmd_push_all(cmd_push_all), .cmd_inv_all(cmd_inv_all),
    .cmd_line_op(cmd_line_op), .cmd_line(cmd_line), .en_req(en_req),
    .wb_ack(wb_ack), .tv(tv), .td(td), .ttag(ttag),
    .hit(hit), .hit_way(hit_way),
    .busy(busy), .cache_en(cache_en), .wb_req(wb_req), .wb_line(wb_line),
    .cur_set(cur_set), .look_tag(look_tag),
    .upd_en(upd_en), .upd_way(upd_way), .upd_v(upd_v), .upd_d(upd_d),
    .walk_last(walk_last), .line_miss(line_miss), .wb_done(wb_done)
  );

endmodule

// File: rtl/cme_checks.sv
module cme_checks #(
  parameter int LINE_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              go,
  input logic              en_req,
  input logic              busy,
  input logic              cache_en,
  input logic              wb_req,
  input logic              wb_ack,
  input logic [LINE_W-1:0] wb_line,
  input logic              upd_en,
  input logic              line_miss
);

  p_wb_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_req && !wb_ack) |=> (wb_req && $stable(wb_line)))
    else $error("write-back request dropped or address moved before acknowledge");

  p_wb_in_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req |-> busy)
    else $error("write-back request outside a command");

  p_busy_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(go) || ($past(en_req) != $past(cache_en))))
    else $error("busy rose without an accepted request");

  p_en_change_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cache_en) |-> $fell(busy))
    else $error("cache enable changed outside the end of a sequence");

  p_miss_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    line_miss |-> (!upd_en && !wb_req))
    else $error("line miss touched state");

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !upd_en)
    else $error("entry updated while idle");

endmodule

bind cache_maint_engine cme_checks #(.LINE_W(LINE_W)) u_checks (
  .clk(clk), .rst_n(rst_n), .go(go), .en_req(en_req), .busy(busy),
  .cache_en(cache_en), .wb_req(wb_req), .wb_ack(wb_ack), .wb_line(wb_line),
  .upd_en(upd_en), .line_miss(line_miss)
);

// File: tb/cache_maint_engine_tb_top.sv
module cache_maint_engine_tb_top;

  localparam int SETS = 16, SET_W = 4, TAG_W = 8, LINE_W = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic go = 0, cmd_push_all = 0, cmd_inv_all = 0, en_req = 0, wb_ack = 0;
  logic [1:0] cmd_line_op = 0;
  logic [LINE_W-1:0] cmd_line = 0;
  logic busy, cache_en, wb_req;
  logic [LINE_W-1:0] wb_line;
  logic fill_en = 0, fill_way = 0, fill_dirty = 0;
  logic [SET_W-1:0] fill_set = 0, peek_set = 0;
  logic [TAG_W-1:0] fill_tag = 0;
  logic [1:0] peek_valid, peek_dirty;
  logic [2*TAG_W-1:0] peek_tag;

  always #10 clk = ~clk;   // 50 MHz

  cache_maint_engine #(.SETS(SETS), .TAG_W(TAG_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .go(go), .cmd_push_all(cmd_push_all),
    .cmd_inv_all(cmd_inv_all), .cmd_line_op(cmd_line_op), .cmd_line(cmd_line),
    .en_req(en_req), .busy(busy), .cache_en(cache_en), .wb_req(wb_req),
    .wb_line(wb_line), .wb_ack(wb_ack), .fill_en(fill_en), .fill_way(fill_way),
    .fill_set(fill_set), .fill_tag(fill_tag), .fill_dirty(fill_dirty),
    .peek_set(peek_set), .peek_valid(peek_valid), .peek_dirty(peek_dirty),
    .peek_tag(peek_tag)
  );

  int checks = 0, errors = 0;
  bit mv [2][SETS];
  bit md [2][SETS];
  logic [TAG_W-1:0] mt [2][SETS];
  logic [LINE_W-1:0] exp_wb [$];

  function automatic logic [LINE_W-1:0] mk_line(logic [TAG_W-1:0] t, int s);
    return {t, 4'(s)};
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic model_entry(int w, int s, bit p, bit i);
    if (p && mv[w][s] && md[w][s]) exp_wb.push_back(mk_line(mt[w][s], s));
    if (i) begin mv[w][s] = 0; md[w][s] = 0; end
    else if (p) md[w][s] = 0;
  endtask

  task automatic model_cmd(bit pa, bit ia, logic [1:0] op, logic [LINE_W-1:0] ln);
    if (pa || ia) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < 2; w++) model_entry(w, s, pa, ia);
    end else if (op != 2'b00) begin
      int s = int'(ln[3:0]);
      if (mv[0][s] && mt[0][s] == ln[11:4]) model_entry(0, s, op[1], op[0]);
      else if (mv[1][s] && mt[1][s] == ln[11:4]) model_entry(1, s, op[1], op[0]);
    end
  endtask

  task automatic check_array(string req);
    bit bad = 0;
    int bs = 0, act = 0, exp = 0;
    for (int s = 0; s < SETS; s++) begin
      peek_set = 4'(s);
      #1;
      for (int w = 0; w < 2; w++) begin
        logic [TAG_W-1:0] t = peek_tag[w*TAG_W +: TAG_W];
        if (!bad && (peek_valid[w] != mv[w][s] || peek_dirty[w] != md[w][s] ||
                     (mv[w][s] && t != mt[w][s]))) begin
          bad = 1; bs = s * 2 + w;
          act = {peek_valid[w], peek_dirty[w], t};
          exp = {mv[w][s], md[w][s], mt[w][s]};
        end
      end
    end
    chk(!bad, req, $sformatf("entry state at set*2+way=%0d", bs), act, exp);
  endtask

  task automatic do_fill(int w, int s, logic [TAG_W-1:0] t, bit d);
    if (mv[1-w][s] && mt[1-w][s] == t) t = t ^ 8'h01;
    @(negedge clk);
    fill_en = 1; fill_way = 1'(w); fill_set = 4'(s); fill_tag = t; fill_dirty = d;
    @(negedge clk);
    fill_en = 0;
    mv[w][s] = 1; md[w][s] = d; mt[w][s] = t;
  endtask

  // Runs from a negedge until busy is low; answers write-backs with random delay.
  task automatic run_idle(string req, int stray, output int cyc);
    int dly = $urandom % 3;
    cyc = 0;
    while (busy) begin
      cyc++;
      go = (cyc == stray);
      if (cyc == stray) begin cmd_push_all = 1; cmd_line_op = 2'b11; end
      if (wb_ack) begin
        wb_ack = 0;
        dly = $urandom % 3;
      end else if (wb_req) begin
        if (dly == 0) begin
          logic [LINE_W-1:0] e = (exp_wb.size() > 0) ? exp_wb.pop_front() : '1;
          chk(wb_line == e, "R7", "write-back line", wb_line, e);
          wb_ack = 1;
        end else dly--;
      end
      @(negedge clk);
    end
    go = 0; wb_ack = 0;
  endtask

  task automatic issue(bit pa, bit ia, logic [1:0] op, logic [LINE_W-1:0] ln,
                       string req, int stray, output int cyc);
    model_cmd(pa, ia, op, ln);
    @(negedge clk);
    go = 1; cmd_push_all = pa; cmd_inv_all = ia; cmd_line_op = op; cmd_line = ln;
    @(negedge clk);
    go = 0;
    cmd_push_all = 1'($urandom); cmd_inv_all = 1'($urandom);
    cmd_line_op = 2'($urandom); cmd_line = 12'($urandom);
    run_idle(req, stray, cyc);
    chk(exp_wb.size() == 0, req, "write-backs outstanding", exp_wb.size(), 0);
    exp_wb.delete();
    check_array(req);
  endtask

  bit done = 0;
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int cyc;
    void'($urandom(32'h5eed_0042));
    for (int s = 0; s < SETS; s++) for (int w = 0; w < 2; w++) begin
      mv[w][s] = 0; md[w][s] = 0; mt[w][s] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(busy == 0, "R1", "busy", busy, 0);
    chk(cache_en == 0, "R1", "cache_en", cache_en, 0);
    chk(wb_req == 0, "R1", "wb_req", wb_req, 0);
    check_array("R1");

    // R11 fills and peek
    do_fill(0, 3, 8'hA5, 1); do_fill(1, 3, 8'h3C, 0);
    do_fill(1, 7, 8'h11, 1); do_fill(0, 9, 8'h42, 1);
    check_array("R11");

    // R3 push on a clean line: no write-back, 2 cycles
    issue(0, 0, 2'b10, mk_line(8'h3C, 3), "R3", 0, cyc);
    chk(cyc == 2, "R3", "clean push busy cycles", cyc, 2);
    // R3 push on a dirty line keeps valid
    issue(0, 0, 2'b10, mk_line(8'hA5, 3), "R3", 0, cyc);
    // R4 clear on dirty then on clean line
    issue(0, 0, 2'b11, mk_line(8'h11, 7), "R4", 0, cyc);
    issue(0, 0, 2'b11, mk_line(8'h3C, 3), "R4", 0, cyc);
    // R2 invalidate a dirty line without write-back
    issue(0, 0, 2'b01, mk_line(8'h42, 9), "R2", 0, cyc);
    // R5 miss
    issue(0, 0, 2'b01, mk_line(8'h77, 5), "R5", 0, cyc);
    chk(cyc == 2, "R5", "miss busy cycles", cyc, 2);
    // R10 no-operation
    issue(0, 0, 2'b00, mk_line(8'hA5, 3), "R10", 0, cyc);
    chk(cyc == 0, "R10", "no-op busy cycles", cyc, 0);

    // R6 clear-all with a line code that must be ignored
    do_fill(0, 0, 8'h01, 1); do_fill(1, 0, 8'h02, 1);
    do_fill(1, 15, 8'hF0, 1); do_fill(0, 8, 8'h80, 0);
    issue(1, 1, 2'b01, mk_line(8'h01, 0), "R6", 0, cyc);
    // R6 invalidate-all length, R8 go while busy ignored
    do_fill(0, 4, 8'h44, 1); do_fill(1, 12, 8'hCC, 1);
    issue(0, 1, 2'b10, mk_line(8'h44, 4), "R8", 5, cyc);
    chk(cyc == 2 * SETS, "R6", "invalidate-all busy cycles", cyc, 2 * SETS);
    @(negedge clk);
    chk(busy == 0, "R8", "busy after ignored go", busy, 0);

    // R9 enable and disable sequences
    do_fill(0, 6, 8'h66, 1);
    model_cmd(0, 1, 2'b00, '0);
    en_req = 1;
    @(negedge clk);
    run_idle("R9", 0, cyc);
    chk(cyc == 2 * SETS, "R9", "enable busy cycles", cyc, 2 * SETS);
    chk(cache_en == 1, "R9", "cache_en after enable", cache_en, 1);
    check_array("R9");
    do_fill(1, 2, 8'h22, 1); do_fill(0, 10, 8'hAA, 0); do_fill(0, 13, 8'hDD, 1);
    model_cmd(1, 0, 2'b00, '0);
    en_req = 0;
    @(negedge clk);
    run_idle("R9", 0, cyc);
    chk(cache_en == 0, "R9", "cache_en after disable", cache_en, 0);
    chk(exp_wb.size() == 0, "R9", "write-backs outstanding", exp_wb.size(), 0);
    check_array("R9");

    // Random mix (R2 R3 R4 R5 R6 R7)
    for (int it = 0; it < 40; it++) begin
      int kind = $urandom % 3;
      for (int f = 0; f < 3; f++)
        do_fill($urandom % 2, $urandom % SETS, 8'($urandom), 1'($urandom));
      if (kind == 0) begin
        int s = $urandom % SETS, w = $urandom % 2;
        logic [1:0] op = 2'($urandom % 3 + 1);
        issue(0, 0, op, mk_line(mt[w][s], s), "R7", 0, cyc);
      end else if (kind == 1) begin
        issue(0, 0, 2'($urandom % 3 + 1), 12'($urandom), "R5", 0, cyc);
      end else begin
        int pi = $urandom % 3 + 1;
        issue(1'(pi >> 1), 1'(pi), 2'($urandom), 12'($urandom), "R6", 0, cyc);
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule